// File: doc/BRIEF.md
# Priority Interrupt Request Arbiter

This block gathers interrupt requests from a fixed number of maskable sources and one non-maskable source. It chooses a single request to offer to the processor. A rising edge on a source's request line sets a sticky pending bit. Software gives each source a 3-bit priority level through a small write port. On every cycle where no offer is outstanding, the block looks for the best pending request whose level passes the processor's current 3-bit mask. When it finds one, it registers an offer made of three parts: an accept strobe, a vector number and the winning level.

The offer stays frozen until the processor acknowledges it, which stands for reading the vector. The acknowledge clears the pending bit of the offered source only. The accept strobe drops for one cycle, and arbitration then runs again on what is still pending. The non-maskable source bypasses the levels and the mask, and it wins over every maskable source.

Top module: `irq_arbiter`

## Requirements
- R1: A maskable source whose level is 0 or 7 is never offered, whatever the mask value.
- R2: A pending maskable source with a level from 1 to 6 is offered when its level is greater than or equal to the mask. A level equal to the mask is therefore accepted.
- R3: Among eligible pending sources, the one with the highest level is offered.
- R4: When eligible sources tie on the highest level, the one with the smaller vector wins.
- R5: A pending non-maskable request is offered whatever the mask and the levels are. It wins over all maskable requests in the same cycle, and it reports level 7.
- R6: A rising edge on a request line sets a sticky pending bit. A line that is held high produces no second request once its first one has been acknowledged.
- R7: An acknowledge clears the pending bit of the offered source only. Other pending sources remain pending and are offered later.
- R8: An acknowledge while accept is low has no effect. An acknowledge while accept is high drops accept on the next cycle.
- R9: While accept is high and no acknowledge arrives, accept, the vector and the level stay unchanged. This holds even if levels change or new requests arrive.
- R10: After reset, accept is low and every source level is 0.
- R11: Maskable source i reports vector i+1. The non-maskable source reports vector 0.
- R12: With the mask at 7, no maskable request is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_SRC | Maskable request lines, rising-edge sensitive |
| nmi_i | input | 1 | Non-maskable request line, rising-edge sensitive |
| lvl_we_i | input | 1 | Level write strobe |
| lvl_idx_i | input | IDX_W | Source index for the level write |
| lvl_data_i | input | 3 | Level value to write |
| mask_i | input | 3 | Processor interrupt mask |
| ack_i | input | 1 | Vector read acknowledge |
| accept_o | output | 1 | Offer outstanding |
| vec_o | output | VEC_W | Offered vector number |
| level_o | output | 3 | Offered level |

## Verification
Suppose a pending bit is set wrongly or never clears. The ports would show a vector offered again after its acknowledge, or a source that is never offered, within about three cycles of the acknowledge. Suppose instead that a level register or the tie-break is wrong. The first offer after the requests arrive would carry the wrong vector or level two cycles after the edge. A broken hold would show up as the vector changing while accept is still high.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W = 3;
  localparam logic [LVL_W-1:0] LVL_TOP = 3'd7;
  typedef logic [LVL_W-1:0] lvl_t;

  // a level of 0 or the top value switches the source off
  function automatic logic lvl_enabled(input lvl_t l);
    return (l != '0) && (l != LVL_TOP);
  endfunction

  function automatic logic lvl_passes(input lvl_t l, input lvl_t mask);
    return lvl_enabled(l) && (l >= mask);
  endfunction
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] line_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] line_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign edge_o[i] = line_i[i] & ~line_q[i];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        line_q[i] <= 1'b0;
        pend_o[i] <= 1'b0;
      end else begin
        line_q[i] <= line_i[i];
        // a fresh edge wins over a clear in the same cycle
        pend_o[i] <= (pend_o[i] & ~clr_i[i]) | edge_o[i];
      end
    end
  end
endmodule

// File: rtl/irq_lvl_regs.sv
module irq_lvl_regs
  import irq_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  logic [IDX_W-1:0]      idx_i,
  input  lvl_t                  data_i,
  output lvl_t [N_SRC-1:0]      lvls_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) lvls_o[i] <= '0;
      else if (we_i && idx_i == IDX_W'(i)) lvls_o[i] <= data_i;
    end
  end
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0]  pend_i,
  input  lvl_t [N_SRC-1:0]  lvls_i,
  input  lvl_t              mask_i,
  output logic              found_o,
  output logic [IDX_W-1:0]  idx_o,
  output lvl_t              lvl_o
);
  logic [N_SRC-1:0] elig;

  for (genvar i = 0; i < N_SRC; i++) begin : g_elig
    assign elig[i] = pend_i[i] && lvl_passes(lvls_i[i], mask_i);
  end

  // scan from the lowest index; only a strictly higher level displaces
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!found_o || lvls_i[i] > lvl_o)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        lvl_o   = lvls_i[i];
      end
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IDX_W = $clog2(N_SRC),
  localparam int VEC_W = $clog2(N_SRC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req_i,
  input  logic             nmi_i,
  input  logic             lvl_we_i,
  input  logic [IDX_W-1:0] lvl_idx_i,
  input  logic [2:0]       lvl_data_i,
  input  logic [2:0]       mask_i,
  input  logic             ack_i,
  output logic             accept_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [2:0]       level_o
);
  logic [N_SRC-1:0] pend, req_edge, clr;
  logic [0:0]       nmi_pend, nmi_edge, nmi_clr;
  lvl_t [N_SRC-1:0] lvls;
  logic             found;
  logic [IDX_W-1:0] win_idx;
  lvl_t             win_lvl;

  // named internal events
  logic ack_hit, load, any_pend;
  assign ack_hit  = ack_i & accept_o;
  assign load     = ~accept_o & (nmi_pend[0] | found);
  assign any_pend = (|pend) | nmi_pend[0];

  for (genvar i = 0; i < N_SRC; i++) begin : g_clr
    assign clr[i] = ack_hit && (vec_o == VEC_W'(i + 1));
  end
  assign nmi_clr[0] = ack_hit && (vec_o == '0);

  irq_pend #(.W(N_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .line_i(req_i), .clr_i(clr),
    .pend_o(pend), .edge_o(req_edge)
  );

  irq_pend #(.W(1)) u_nmi (
    .clk(clk), .rst_n(rst_n), .line_i(nmi_i), .clr_i(nmi_clr),
    .pend_o(nmi_pend), .edge_o(nmi_edge)
  );

  irq_lvl_regs #(.N_SRC(N_SRC)) u_lvl (
    .clk(clk), .rst_n(rst_n), .we_i(lvl_we_i), .idx_i(lvl_idx_i),
    .data_i(lvl_data_i), .lvls_o(lvls)
  );

  irq_select #(.N_SRC(N_SRC)) u_sel (
    .pend_i(pend), .lvls_i(lvls), .mask_i(mask_i),
    .found_o(found), .idx_o(win_idx), .lvl_o(win_lvl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accept_o <= 1'b0;
      vec_o    <= '0;
      level_o  <= '0;
    end else if (load) begin
      accept_o <= 1'b1;
      if (nmi_pend[0]) begin
        vec_o   <= '0;
        level_o <= LVL_TOP;
      end else begin
        vec_o   <= VEC_W'(win_idx) + VEC_W'(1);
        level_o <= win_lvl;
      end
    end else if (ack_hit) begin
      accept_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int VEC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             accept_o,
  input logic             ack_i,
  input logic [VEC_W-1:0] vec_o,
  input logic [2:0]       level_o,
  input logic [2:0]       mask_i,
  input logic             any_pend
);
  // R2 and R1: a maskable offer passed the mask and is an enabled level
  a_r2_level_passes_mask: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(accept_o) && vec_o != '0 |->
      level_o >= $past(mask_i) && level_o != 3'd0 && level_o != 3'd7);

  // R5: the non-maskable vector always carries the top level
  a_r5_nmi_level: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o && vec_o == '0 |-> level_o == 3'd7);

  // R9: the offer is frozen until it is acknowledged
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o && !ack_i |=> accept_o && $stable(vec_o) && $stable(level_o));

  // R8: an acknowledge of the offer drops accept
  a_r8_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    accept_o && ack_i |=> !accept_o);

  // R6: no offer appears without a pending request behind it
  a_r6_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_o |=> !accept_o || $past(any_pend));
endmodule

bind irq_arbiter irq_arbiter_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept_o(accept_o), .ack_i(ack_i),
  .vec_o(vec_o), .level_o(level_o), .mask_i(mask_i), .any_pend(any_pend)
);

// File: tb/irq_arbiter_test.sv
module irq_arbiter_test;
  localparam int N = 8;
  localparam int IW = $clog2(N);
  localparam int VW = $clog2(N + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] req_i = '0;
  logic nmi_i = 1'b0, lvl_we_i = 1'b0, ack_i = 1'b0;
  logic [IW-1:0] lvl_idx_i = '0;
  logic [2:0] lvl_data_i = '0, mask_i = 3'd7;
  logic accept_o;
  logic [VW-1:0] vec_o;
  logic [2:0] level_o;

  int n_chk = 0, n_fail = 0;
  logic [N-1:0] pend_m;
  logic nmi_m;
  logic [2:0] lvl_m [N];
  logic e_acc;
  logic [VW-1:0] e_vec;
  logic [2:0] e_lvl;

  always #5 clk = ~clk;

  irq_arbiter #(.N_SRC(N)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .nmi_i(nmi_i),
    .lvl_we_i(lvl_we_i), .lvl_idx_i(lvl_idx_i), .lvl_data_i(lvl_data_i),
    .mask_i(mask_i), .ack_i(ack_i), .accept_o(accept_o), .vec_o(vec_o),
    .level_o(level_o)
  );

  // expected offer: walk levels from 6 down, sources in vector order
  task automatic predict();
    e_acc = 1'b0; e_vec = '0; e_lvl = '0;
    if (nmi_m) begin
      e_acc = 1'b1; e_vec = '0; e_lvl = 3'd7;
      return;
    end
    for (int l = 6; l >= 1; l--) begin
      if (l < int'(mask_i)) break;
      for (int s = 0; s < N; s++) begin
        if (!e_acc && pend_m[s] && int'(lvl_m[s]) == l) begin
          e_acc = 1'b1; e_vec = VW'(s + 1); e_lvl = 3'(l);
        end
      end
      if (e_acc) return;
    end
  endtask

  task automatic check(input string tag);
    n_chk++;
    if (accept_o !== e_acc || (e_acc && (vec_o !== e_vec || level_o !== e_lvl))) begin
      n_fail++;
      $display("FAIL %s: acc/vec/lvl actual %0b/%0d/%0d expected %0b/%0d/%0d",
               tag, accept_o, vec_o, level_o, e_acc, e_vec, e_lvl);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; req_i = '0; nmi_i = 1'b0; ack_i = 1'b0;
    ticks(2); rst_n = 1'b1;
    pend_m = '0; nmi_m = 1'b0;
    for (int i = 0; i < N; i++) lvl_m[i] = 3'd0;
  endtask

  task automatic set_lvl(input int s, input logic [2:0] v);
    lvl_we_i = 1'b1; lvl_idx_i = IW'(s); lvl_data_i = v;
    ticks(1); lvl_we_i = 1'b0; lvl_m[s] = v;
  endtask

  task automatic pulse(input logic [N-1:0] bits, input logic nmi);
    req_i = bits; nmi_i = nmi; ticks(1);
    req_i = '0; nmi_i = 1'b0;
    pend_m |= bits; nmi_m |= nmi;
    ticks(3);
  endtask

  // acknowledge the current offer and update the model
  task automatic ack_one();
    predict();
    ack_i = 1'b1; ticks(1); ack_i = 1'b0;
    if (e_acc) begin
      if (e_vec == '0) nmi_m = 1'b0; else pend_m[e_vec - 1] = 1'b0;
    end
    ticks(3);
  endtask

  task automatic drain(input string tag);
    for (int k = 0; k < N + 2; k++) begin
      predict(); check(tag);
      if (!e_acc) break;
      ack_one();
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    do_reset();
    // R10: reset state, levels zero so a pending source stays unoffered
    mask_i = 3'd0;
    ticks(1); predict(); check("R10 reset");
    pulse(8'h01, 1'b0); predict(); check("R10 levels zero");
    // R12: mask 7 blocks everything maskable
    do_reset(); mask_i = 3'd7;
    for (int s = 0; s < N; s++) set_lvl(s, 3'(1 + s % 6));
    pulse(8'hFF, 1'b0); predict(); check("R12 mask7");
    // R1: levels 0 and 7 disabled even with mask 0
    do_reset(); mask_i = 3'd0; set_lvl(2, 3'd7); set_lvl(3, 3'd0);
    pulse(8'h0C, 1'b0); predict(); check("R1 disabled");
    // R2: equal level accepted, lower rejected
    do_reset(); mask_i = 3'd4; set_lvl(5, 3'd4); set_lvl(1, 3'd3);
    pulse(8'h22, 1'b0); drain("R2 equal passes");
    // R3 / R4 / R11 ordering
    do_reset(); mask_i = 3'd1;
    set_lvl(0, 3'd2); set_lvl(3, 3'd5); set_lvl(6, 3'd5); set_lvl(7, 3'd6);
    pulse(8'hC9, 1'b0); drain("R3 R4 R11 order");
    // R5: NMI beats level 6 even with mask 7
    do_reset(); mask_i = 3'd7; set_lvl(4, 3'd6);
    pulse(8'h10, 1'b1); drain("R5 nmi");
    // R7: ack clears only the offered source
    do_reset(); mask_i = 3'd1; set_lvl(1, 3'd3); set_lvl(2, 3'd3);
    pulse(8'h06, 1'b0); drain("R7 others kept");
    // R8: ack with no offer leaves pending intact
    do_reset(); mask_i = 3'd1; pulse(8'h08, 1'b0);
    ack_i = 1'b1; ticks(1); ack_i = 1'b0;
    set_lvl(3, 3'd2); ticks(3); predict(); check("R8 idle ack ignored");
    ack_one(); predict(); check("R8 accept drops");
    // R9: hold while level changes and a higher request arrives
    do_reset(); mask_i = 3'd1; set_lvl(0, 3'd2); set_lvl(5, 3'd6);
    pulse(8'h01, 1'b0); predict(); check("R9 first offer");
    lvl_we_i = 1'b1; lvl_idx_i = IW'(0); lvl_data_i = 3'd0; ticks(1); lvl_we_i = 1'b0;
    req_i = 8'h20; ticks(1); req_i = '0; ticks(3);
    check("R9 held");
    ack_i = 1'b1; ticks(1); ack_i = 1'b0; ticks(3);
    lvl_m[0] = 3'd0; pend_m = 8'h20; predict(); check("R9 next after ack");
    // R6: line held high gives one request only
    do_reset(); mask_i = 3'd1; set_lvl(4, 3'd3);
    req_i = 8'h10; ticks(3); pend_m = 8'h10; predict(); check("R6 edge latched");
    ack_i = 1'b1; ticks(1); ack_i = 1'b0; pend_m = '0; ticks(4);
    predict(); check("R6 held line no retrigger");
    req_i = '0; ticks(2);
    // random mix covering R2 R3 R4 R5 R7
    for (int it = 0; it < 40; it++) begin
      do_reset();
      mask_i = 3'($urandom_range(0, 7));
      for (int s = 0; s < N; s++) set_lvl(s, 3'($urandom_range(0, 7)));
      pulse(N'($urandom), ($urandom_range(0, 9) == 0));
      drain("R3 R4 R7 random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule